// File: doc/BRIEF.md
# Buck Gate-Drive Sequencer

This block decides, on every clock, whether the high-side and the low-side switch of a synchronous buck stage may conduct. It receives already-digitised comparator results: two flags that place the PWM command above its upper threshold or below its lower threshold, a switch-node-low flag, a high-side-gate-low flag, a supply-good flag and a switch-node over-voltage flag. From these it drives two gate-enable outputs. The break-before-make ordering differs by direction. A rising command drops the low side at once and raises the high side after a fixed dead time. A falling command drops the high side at once and raises the low side only once the gate and the switch node both read low.

A PWM level that sits between the two thresholds long enough is decoded as a shutdown request and forces both gates off. Shorter excursions through that window, such as normal edges, keep the last valid command. The start-up phase lasts from reset, or from a drop of the supply flag, until the first clock where the supply is good and the PWM level is valid. During start-up, an over-voltage on the switch node latches a clamp that holds the low side on and ignores the PWM input until the supply flag falls.

Top module: `buck_gate_sequencer`

## Requirements
- R1: While reset is applied, and on every clock after one where `supply_ok` was sampled low, `hs_en` is 0. Outside the start-up clamp of R8, `ls_en` is also 0 in those cycles.
- R2: When the command turns high, `ls_en` falls at the next clock edge. `hs_en` rises only after both enables have been low for exactly `NOV_CYCLES` cycles.
- R3: When the command turns low, `hs_en` falls at the next clock edge. `ls_en` then rises at the first edge at which `hs_gate_low` and `sw_low` are both sampled 1.
- R4: If those two flags do not both read 1 within `LS_TIMEOUT` cycles of the high side turning off, `ls_en` rises anyway and `lsto_fault` goes to 1 at the same edge. `lsto_fault` stays 1 until reset or until `supply_ok` drops.
- R5: `pwm_above_hi`=1 reads as high. `pwm_below_lo`=1 with `pwm_above_hi`=0 reads as low. Both flags at 0 is the mid window. A mid run shorter than `TRI_CYCLES` sampled cycles keeps the last valid command and does not raise `tri_state`.
- R6: After `TRI_CYCLES` consecutive mid samples, `tri_state` goes to 1. One cycle later both enables are 0, and they stay 0 while the mid level persists.
- R7: On leaving tri-state, sequencing resumes from the new valid level through the break-before-make path. A low level still waits for the flags of R3. A high level still waits out the dead time of R2.
- R8: During start-up, `sw_ovp`=1 sets `ovp_clamp` and `ls_en` at the next edge, with `hs_en` held at 0.
- R9: Once set, `ovp_clamp` keeps `ls_en` at 1 whatever the PWM flags do. It clears, with `ls_en`, one edge after `supply_ok` falls.
- R10: After start-up has ended, `sw_ovp` has no effect on any output.
- R11: `hs_en` and `ls_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| pwm_above_hi | input | 1 | PWM level is above the upper threshold |
| pwm_below_lo | input | 1 | PWM level is below the lower threshold |
| sw_low | input | 1 | Switch node reads low |
| hs_gate_low | input | 1 | High-side gate reads low |
| supply_ok | input | 1 | Supply-good flag, hysteresis applied upstream |
| sw_ovp | input | 1 | Switch node reads over-voltage |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| tri_state | output | 1 | Mid-window level decoded as shutdown |
| lsto_fault | output | 1 | Sticky low-side turn-on timeout flag |
| ovp_clamp | output | 1 | Start-up over-voltage clamp latched |

## Verification
The bench builds the block with `NOV_CYCLES`=3, `TRI_CYCLES`=5 and `LS_TIMEOUT`=12. With these small windows, each one can be probed in a few dozen clocks both one cycle before it expires and at the cycle it expires. The dead time, the shutdown decode and the forced low-side turn-on are each checked at that boundary, while the short-mid case sits one sample under the shutdown count. The same values let a single run walk through timeout, the sticky fault, tri-state entry and exit in both directions, and a clamp cycle bounded by supply drops.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_LOW   = 3'd1,
    PH_DEAD  = 3'd2,
    PH_HIGH  = 3'd3,
    PH_SETTL = 3'd4,
    PH_CLAMP = 3'd5
  } phase_t;

endpackage

// File: rtl/gdrv_level_decode.sv
module gdrv_level_decode #(
  parameter int TRI_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi,
  input  logic below_lo,
  output logic lvl_valid,
  output logic cmd_hi,
  output logic tri_state
);

  localparam int MW = $clog2(TRI_CYCLES + 1);
  localparam logic [MW-1:0] TRI_V = MW'(TRI_CYCLES);

  logic          is_hi, is_lo, is_mid;
  logic [MW-1:0] mid_cnt_q, mid_cnt_d;
  logic          last_hi_q, last_hi_d;
  logic          cnt_en, hold_en;

  always_comb begin
    is_hi  = above_hi;
    is_lo  = below_lo & ~above_hi;
    is_mid = ~above_hi & ~below_lo;

    cnt_en    = ~(is_mid & (mid_cnt_q == TRI_V));
    mid_cnt_d = is_mid ? (mid_cnt_q + MW'(1)) : '0;

    hold_en   = ~is_mid;
    last_hi_d = is_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_cnt_q <= '0;
      last_hi_q <= 1'b0;
    end else begin
      if (cnt_en)  mid_cnt_q <= mid_cnt_d;
      if (hold_en) last_hi_q <= last_hi_d;
    end
  end

  assign lvl_valid = ~is_mid;
  assign cmd_hi    = is_mid ? last_hi_q : is_hi;
  assign tri_state = (mid_cnt_q == TRI_V);

endmodule

// File: rtl/gdrv_start_guard.sv
module gdrv_start_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sw_ovp,
  input  logic lvl_valid,
  output logic soft_clr,
  output logic clamp_req,
  output logic run,
  output logic ovp_latched
);

  logic sup_q;
  logic armed_q, armed_d;
  logic latch_q, latch_d;
  logic ovp_hit;

  always_comb begin
    soft_clr = sup_q & ~supply_ok;
    ovp_hit  = ~armed_q & sw_ovp;
    latch_d  = soft_clr ? 1'b0 : (latch_q | ovp_hit);
    armed_d  = soft_clr ? 1'b0
             : (armed_q | (supply_ok & lvl_valid & ~latch_q & ~ovp_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q   <= 1'b0;
      armed_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sup_q   <= supply_ok;
      armed_q <= armed_d;
      latch_q <= latch_d;
    end
  end

  assign clamp_req   = ~soft_clr & (latch_q | ovp_hit);
  assign run         = armed_q & supply_ok;
  assign ovp_latched = latch_q;

endmodule

// File: rtl/gdrv_phase_fsm.sv
module gdrv_phase_fsm
  import gdrv_pkg::*;
#(
  parameter int NOV_CYCLES = 4,
  parameter int LS_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic clamp_req,
  input  logic run,
  input  logic tri_state,
  input  logic cmd_hi,
  input  logic hs_gate_low,
  input  logic sw_low,
  output logic hs_en,
  output logic ls_en,
  output logic to_fault
);

  localparam int CMAX = (NOV_CYCLES > LS_TIMEOUT) ? NOV_CYCLES : LS_TIMEOUT;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] NOV_LAST = CW'(NOV_CYCLES - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(LS_TIMEOUT - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q, flt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    flt_d = flt_q;
    if (soft_clr) begin
      ph_d  = PH_OFF;
      cnt_d = '0;
      flt_d = 1'b0;
    end else if (clamp_req) begin
      ph_d = PH_CLAMP;
    end else if (!run || tri_state) begin
      ph_d  = PH_OFF;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_OFF: begin
          cnt_d = '0;
          ph_d  = cmd_hi ? PH_DEAD : PH_SETTL;
        end
        PH_LOW: begin
          if (cmd_hi) begin
            ph_d  = PH_DEAD;
            cnt_d = '0;
          end
        end
        PH_DEAD: begin
          if (!cmd_hi) begin
            ph_d  = PH_SETTL;
            cnt_d = '0;
          end else if (cnt_q == NOV_LAST) begin
            ph_d = PH_HIGH;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        PH_HIGH: begin
          if (!cmd_hi) begin
            ph_d  = PH_SETTL;
            cnt_d = '0;
          end
        end
        PH_SETTL: begin
          if (cmd_hi) begin
            ph_d  = PH_DEAD;
            cnt_d = '0;
          end else if (hs_gate_low && sw_low) begin
            ph_d = PH_LOW;
          end else if (cnt_q == TMO_LAST) begin
            ph_d  = PH_LOW;
            flt_d = 1'b1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          ph_d  = PH_OFF;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_OFF;
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign hs_en    = (ph_q == PH_HIGH);
  assign ls_en    = (ph_q == PH_LOW) || (ph_q == PH_CLAMP);
  assign to_fault = flt_q;

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer #(
  parameter int NOV_CYCLES = 4,
  parameter int TRI_CYCLES = 8,
  parameter int LS_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_above_hi,
  input  logic pwm_below_lo,
  input  logic sw_low,
  input  logic hs_gate_low,
  input  logic supply_ok,
  input  logic sw_ovp,
  output logic hs_en,
  output logic ls_en,
  output logic tri_state,
  output logic lsto_fault,
  output logic ovp_clamp
);

  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       lvl_valid, cmd_hi, tri_w;
  logic       soft_clr, clamp_req, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  gdrv_level_decode #(.TRI_CYCLES(TRI_CYCLES)) u_decode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .above_hi  (pwm_above_hi),
    .below_lo  (pwm_below_lo),
    .lvl_valid (lvl_valid),
    .cmd_hi    (cmd_hi),
    .tri_state (tri_w)
  );

  gdrv_start_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .supply_ok   (supply_ok),
    .sw_ovp      (sw_ovp),
    .lvl_valid   (lvl_valid),
    .soft_clr    (soft_clr),
    .clamp_req   (clamp_req),
    .run         (run),
    .ovp_latched (ovp_clamp)
  );

  gdrv_phase_fsm #(.NOV_CYCLES(NOV_CYCLES), .LS_TIMEOUT(LS_TIMEOUT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .soft_clr    (soft_clr),
    .clamp_req   (clamp_req),
    .run         (run),
    .tri_state   (tri_w),
    .cmd_hi      (cmd_hi),
    .hs_gate_low (hs_gate_low),
    .sw_low      (sw_low),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .to_fault    (lsto_fault)
  );

  assign tri_state = tri_w;

endmodule

// File: rtl/buck_gate_sequencer_chk.sv
module buck_gate_sequencer_chk #(
  parameter int NOV_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic hs_gate_low,
  input logic sw_low,
  input logic hs_en,
  input logic ls_en,
  input logic tri_state,
  input logic lsto_fault,
  input logic ovp_clamp
);

  localparam int RW = $clog2(NOV_CYCLES + 2);
  localparam logic [RW-1:0] RUN_SAT = RW'(NOV_CYCLES);

  logic [RW-1:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lo_run <= '0;
    else if (hs_en || ls_en)   lo_run <= '0;
    else if (lo_run != RUN_SAT) lo_run <= lo_run + RW'(1);
  end

  a_r1_supply_low_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !hs_en);

  a_r2_dead_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> (lo_run >= RUN_SAT));

  a_r3_ls_waits_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_en) && !ovp_clamp && !$rose(lsto_fault)) |-> $past(hs_gate_low && sw_low));

  a_r4_fault_with_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsto_fault) |-> $rose(ls_en));

  a_r6_tri_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_state && $past(tri_state) && !ovp_clamp) |-> (!hs_en && !ls_en));

  a_r8_clamp_drives_ls: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_clamp |-> (ls_en && !hs_en));

  a_r9_clamp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_clamp && supply_ok) |=> ovp_clamp);

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

endmodule

bind buck_gate_sequencer buck_gate_sequencer_chk #(.NOV_CYCLES(NOV_CYCLES)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok   (supply_ok),
  .hs_gate_low (hs_gate_low),
  .sw_low      (sw_low),
  .hs_en       (hs_en),
  .ls_en       (ls_en),
  .tri_state   (tri_state),
  .lsto_fault  (lsto_fault),
  .ovp_clamp   (ovp_clamp)
);

// File: tb/test_buck_gate_sequencer.sv
module test_buck_gate_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NOV = 3;
  localparam int TRI = 5;
  localparam int TMO = 12;
  localparam int WDOG_CYCLES = 5000;

  logic clk, rst_n;
  logic above, below, sw_low, hs_low, supply, ovp;
  logic hs_en, ls_en, tri_st, fault, clamp;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  buck_gate_sequencer #(.NOV_CYCLES(NOV), .TRI_CYCLES(TRI), .LS_TIMEOUT(TMO)) i_buck_gate_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_above_hi (above),
    .pwm_below_lo (below),
    .sw_low       (sw_low),
    .hs_gate_low  (hs_low),
    .supply_ok    (supply),
    .sw_ovp       (ovp),
    .hs_en        (hs_en),
    .ls_en        (ls_en),
    .tri_state    (tri_st),
    .lsto_fault   (fault),
    .ovp_clamp    (clamp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; supply = 1'b0; above = 1'b0; below = 1'b1;
    sw_low = 1'b1; hs_low = 1'b1; ovp = 1'b0;
    tick(3);
    chk("R1", "hs_en in reset", hs_en, 1'b0);
    chk("R1", "ls_en in reset", ls_en, 1'b0);
    chk("R1", "fault in reset", fault, 1'b0);
    chk("R1", "clamp in reset", clamp, 1'b0);
    chk("R1", "tri in reset", tri_st, 1'b0);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic t_power_up;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      chk("R1", "ls_en supply low", ls_en, 1'b0);
      chk("R1", "hs_en supply low", hs_en, 1'b0);
    end
    supply = 1'b1;
    tick(2);
    chk("R3", "ls_en before settle", ls_en, 1'b0);
    tick(1);
    chk("R3", "ls_en after power-up", ls_en, 1'b1);
  endtask

  task automatic t_rise;
    above = 1'b1; below = 1'b0;
    tick(1);
    chk("R2", "ls_en off next edge", ls_en, 1'b0);
    chk("R2", "hs_en still off", hs_en, 1'b0);
    tick(NOV - 1);
    chk("R2", "hs_en at dead-time end", hs_en, 1'b0);
    tick(1);
    chk("R2", "hs_en after dead time", hs_en, 1'b1);
    chk("R11", "ls_en while hs on", ls_en, 1'b0);
    hs_low = 1'b0; sw_low = 1'b0;
  endtask

  task automatic t_fall_flags(input logic exp_fault);
    above = 1'b0; below = 1'b1;
    tick(1);
    chk("R3", "hs_en off next edge", hs_en, 1'b0);
    chk("R3", "ls_en waits", ls_en, 1'b0);
    hs_low = 1'b1;
    tick(2);
    chk("R3", "ls_en waits for sw_low", ls_en, 1'b0);
    sw_low = 1'b1;
    tick(1);
    chk("R3", "ls_en on after flags", ls_en, 1'b1);
    chk("R4", "fault level", fault, exp_fault);
  endtask

  task automatic t_short_mid(input logic was_hi);
    above = 1'b0; below = 1'b0;
    for (int i = 0; i < TRI - 1; i++) begin
      tick(1);
      chk("R5", "tri during short mid", tri_st, 1'b0);
      chk("R5", "hs_en held", hs_en, was_hi);
      chk("R5", "ls_en held", ls_en, ~was_hi);
    end
    above = was_hi; below = ~was_hi;
    tick(1);
    chk("R5", "hs_en after short mid", hs_en, was_hi);
    chk("R5", "ls_en after short mid", ls_en, ~was_hi);
  endtask

  task automatic t_timeout;
    above = 1'b0; below = 1'b1; hs_low = 1'b1;
    tick(TMO);
    chk("R4", "ls_en before timeout", ls_en, 1'b0);
    chk("R4", "fault before timeout", fault, 1'b0);
    tick(1);
    chk("R4", "ls_en at timeout", ls_en, 1'b1);
    chk("R4", "fault at timeout", fault, 1'b1);
    sw_low = 1'b1;
  endtask

  task automatic t_tristate_low;
    above = 1'b0; below = 1'b0;
    tick(TRI);
    chk("R6", "tri after window", tri_st, 1'b1);
    tick(1);
    chk("R6", "ls_en off in tri", ls_en, 1'b0);
    chk("R6", "hs_en off in tri", hs_en, 1'b0);
    tick(3);
    chk("R6", "ls_en held off", ls_en, 1'b0);
    chk("R6", "tri held", tri_st, 1'b1);
    below = 1'b1; sw_low = 1'b0;
    tick(1);
    chk("R7", "tri cleared", tri_st, 1'b0);
    tick(3);
    chk("R7", "ls_en waits after tri", ls_en, 1'b0);
    sw_low = 1'b1;
    tick(1);
    chk("R7", "ls_en on after flags", ls_en, 1'b1);
  endtask

  task automatic t_tristate_high;
    above = 1'b0; below = 1'b0;
    tick(TRI + 1);
    chk("R6", "ls_en off in tri", ls_en, 1'b0);
    above = 1'b1;
    tick(1 + NOV);
    chk("R7", "hs_en waits dead time", hs_en, 1'b0);
    chk("R7", "ls_en stays off", ls_en, 1'b0);
    tick(1);
    chk("R7", "hs_en on after tri", hs_en, 1'b1);
    hs_low = 1'b0; sw_low = 1'b0;
  endtask

  task automatic t_ovp_clamp;
    supply = 1'b0;
    tick(1);
    chk("R1", "ls_en after supply drop", ls_en, 1'b0);
    chk("R4", "fault cleared by drop", fault, 1'b0);
    ovp = 1'b1;
    tick(1);
    chk("R8", "clamp set", clamp, 1'b1);
    chk("R8", "ls_en clamped", ls_en, 1'b1);
    chk("R8", "hs_en off in clamp", hs_en, 1'b0);
    supply = 1'b1; above = 1'b1; below = 1'b0; ovp = 1'b0;
    tick(5);
    chk("R9", "clamp held", clamp, 1'b1);
    chk("R9", "ls_en held", ls_en, 1'b1);
    chk("R9", "hs_en ignores pwm", hs_en, 1'b0);
    supply = 1'b0; above = 1'b0; below = 1'b1;
    tick(1);
    chk("R9", "clamp released", clamp, 1'b0);
    chk("R9", "ls_en released", ls_en, 1'b0);
  endtask

  task automatic t_ovp_ignored;
    ovp = 1'b1;
    tick(4);
    chk("R10", "clamp stays clear", clamp, 1'b0);
    chk("R10", "ls_en unchanged", ls_en, 1'b1);
    t_rise();
    chk("R10", "clamp after rise", clamp, 1'b0);
    ovp = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL WDOG run incomplete actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    t_reset();
    t_power_up();
    t_rise();
    t_fall_flags(1'b0);
    t_short_mid(1'b0);
    t_rise();
    t_short_mid(1'b1);
    t_timeout();
    t_rise();
    t_fall_flags(1'b1);
    t_tristate_low();
    t_tristate_high();
    t_fall_flags(1'b1);
    t_ovp_clamp();
    t_power_up();
    t_ovp_ignored();
    tick(2);
    report();
  end

endmodule